// File: doc/BRIEF.md
# Matrix Keypad Row Scanner

This block scans a four-by-four switch matrix. Each column line is pulled high outside the chip. The block pulls one row line low at a time and reads all four column lines together. A closed switch on the active row shows as a zero on its column. When the block finds a key, it stops on that row and checks that the key reads the same over several consecutive samples. It then reports the key's code with a one-cycle valid pulse. It stays on that row, holding a held flag, until every column has read high for the same number of samples. After that it moves on to the next row.

The column inputs are asynchronous. They go through a two-flop synchronizer before any logic uses them. After each row change the block waits a programmable number of settle cycles before it samples the columns. The key code is the row index times the column count plus the column index. If more than one column on the strobed row is low, the lowest-numbered column is reported.

Top module: `kpd_scanner`

## Requirements
- R1: While reset is low at a clock edge, the block returns to row 0 (row drive 1110, bit i driving row i), with key_valid low, key_held low and key_code zero.
- R2: Exactly one row line is low at any time. While idle, the drive steps 1110, 1101, 1011, 0111 and then wraps to 1110. Each row stays low for SETTLE clock cycles.
- R3: Columns are read through a two-stage synchronizer. A row is sampled only on the last settle cycle. If no column is low, the scan moves to the next row.
- R4: The reported key code is row*COLS + column. With four columns, row 0 column 0 gives 0, row 0 column 1 gives 1, row 2 column 1 gives 9, and row 3 column 3 gives 15.
- R5: key_valid fires only after DEBOUNCE consecutive synchronized samples show the same lowest low column. A mismatch before that count ends the check, and the same row is settled again. A key that bounces faster than the count never fires.
- R6: key_valid is a single-cycle pulse, issued once per press, in the same cycle that key_held first goes high. key_held stays high while the key is held.
- R7: While a key is being confirmed or held, the row drive does not change.
- R8: A held key is released only after DEBOUNCE consecutive samples with all columns high. In that cycle key_held falls and the drive advances to the next row.
- R9: When several columns of the strobed row are low, the lowest-numbered column is the one reported.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| col_n | input | COLS (4) | Raw column lines; 0 means a closed switch on the strobed row |
| row_n | output | ROWS (4) | Row drive; the single low bit is the strobed row |
| key_code | output | clog2(ROWS*COLS) (4) | Code of the last confirmed key |
| key_valid | output | 1 | One-cycle pulse when a key is confirmed |
| key_held | output | 1 | High while a confirmed key is still pressed |

## Verification
The assertions check these properties on every cycle:
- exactly one row line is low;
- the row drive only ever rotates by one position;
- the debounce counter stays below its limit;
- the valid pulse lasts a single cycle and coincides with the held state;
- the drive stays put while a key is held;
- releasing a key always moves the scan on.

The bench scenarios show the behaviours that need a modelled keypad. These are the exact code for a given row and column, the lowest-column choice when two switches close together, and the rejection of a bouncing contact. They also cover the exact settle and debounce cycle counts, which are compared against a behavioural model on every clock.

// File: rtl/kpd_pkg.sv
// Package: shared types for the keypad scanner.
// Assumes: the control FSM needs only the three states below.
package kpd_pkg;
    typedef enum logic [1:0] {
        ST_SCAN    = 2'd0,
        ST_CONFIRM = 2'd1,
        ST_HELD    = 2'd2
    } scan_state_t;
endpackage

// File: rtl/kpd_sync.sv
// Two-flop synchronizer for the raw column lines.
// Assumes: the inputs are asynchronous and idle high. The reset value is all ones (no key).
module kpd_sync #(
    parameter int W = 4
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout
);
    logic [W-1:0] stage1;

    // two-stage capture of the asynchronous inputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= '1;
            dout   <= '1;
        end else begin
            stage1 <= din;
            dout   <= stage1;
        end
    end
endmodule

// File: rtl/kpd_row_drv.sv
// Walking-zero row driver with a settle counter.
// It steps to the next row on adv and restarts settling on restart.
// It raises sample_tick on the last settle cycle while scan_en is high.
// Assumes: SETTLE >= 3, so the synchronized columns reflect the current row when sampled.
module kpd_row_drv #(
    parameter int ROWS   = 4,
    parameter int SETTLE = 4,
    localparam int RW    = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int SW    = (SETTLE > 1) ? $clog2(SETTLE) : 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            scan_en,
    input  logic            adv,
    input  logic            restart,
    output logic [RW-1:0]   row_idx,
    output logic [ROWS-1:0] row_n,
    output logic            sample_tick
);
    localparam logic [SW-1:0] SET_LAST = SW'(SETTLE - 1);
    localparam logic [RW-1:0] ROW_LAST = RW'(ROWS - 1);

    logic [SW-1:0] settle_cnt;

    // row index and settle counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            row_idx    <= '0;
            settle_cnt <= '0;
        end else if (adv) begin
            row_idx    <= (row_idx == ROW_LAST) ? '0 : row_idx + 1'b1;
            settle_cnt <= '0;
        end else if (restart) begin
            settle_cnt <= '0;
        end else if (scan_en && settle_cnt != SET_LAST) begin
            settle_cnt <= settle_cnt + 1'b1;
        end
    end

    assign sample_tick = scan_en && (settle_cnt == SET_LAST);

    // one active-low strobe per row
    genvar g;
    generate
        for (g = 0; g < ROWS; g++) begin : g_row
            assign row_n[g] = (row_idx != RW'(g));
        end
    endgenerate

    assert_one_row_low_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(~row_n) == 1);

    assert_row_rotates_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (row_n != $past(row_n)) |-> (row_n == {$past(row_n[ROWS-2:0]), $past(row_n[ROWS-1])}));

    initial begin
        assert (SETTLE >= 3) else $error("SETTLE must be at least 3");
    end
endmodule

// File: rtl/kpd_debounce.sv
// Key detection, confirmation and release FSM.
// It watches the synchronized columns of the strobed row. It confirms the lowest low
// column over DEBOUNCE consecutive samples, then holds until DEBOUNCE all-high samples.
// Assumes: DEBOUNCE >= 2, and the row stays unchanged while adv is low.
module kpd_debounce
    import kpd_pkg::*;
#(
    parameter int ROWS     = 4,
    parameter int COLS     = 4,
    parameter int DEBOUNCE = 4,
    localparam int RW      = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int CW      = (COLS > 1) ? $clog2(COLS) : 1,
    localparam int KW      = $clog2(ROWS * COLS),
    localparam int DW      = $clog2(DEBOUNCE + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [COLS-1:0] col_s,
    input  logic [RW-1:0]   row_idx,
    input  logic            sample_tick,
    output logic            scan_en,
    output logic            adv,
    output logic            restart,
    output logic [KW-1:0]   key_code,
    output logic            key_valid,
    output logic            key_held
);
    localparam logic [DW-1:0] DEB_LAST = DW'(DEBOUNCE - 1);

    scan_state_t     state;
    logic [DW-1:0]   deb_cnt;
    logic [CW-1:0]   cand;
    logic [COLS-1:0] pressed;
    logic            hit;
    logic [CW-1:0]   low_col;
    logic            same;

    // active-high pressed mask and lowest pressed column
    always_comb begin
        pressed = ~col_s;
        hit     = |pressed;
        low_col = '0;
        for (int c = COLS - 1; c >= 0; c--) begin
            if (pressed[c]) low_col = CW'(c);
        end
        same = hit && (low_col == cand);
    end

    // state, debounce count, candidate column and reported code
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_SCAN;
            deb_cnt   <= '0;
            cand      <= '0;
            key_code  <= '0;
            key_valid <= 1'b0;
        end else begin
            key_valid <= 1'b0;
            case (state)
                ST_SCAN: begin
                    if (sample_tick && hit) begin
                        state   <= ST_CONFIRM;
                        cand    <= low_col;
                        deb_cnt <= DW'(1);
                    end
                end
                ST_CONFIRM: begin
                    if (same) begin
                        if (deb_cnt == DEB_LAST) begin
                            state     <= ST_HELD;
                            key_valid <= 1'b1;
                            key_code  <= KW'(int'(row_idx) * COLS + int'(cand));
                            deb_cnt   <= '0;
                        end else begin
                            deb_cnt <= deb_cnt + 1'b1;
                        end
                    end else begin
                        state   <= ST_SCAN;
                        deb_cnt <= '0;
                    end
                end
                ST_HELD: begin
                    if (!hit) begin
                        if (deb_cnt == DEB_LAST) begin
                            state   <= ST_SCAN;
                            deb_cnt <= '0;
                        end else begin
                            deb_cnt <= deb_cnt + 1'b1;
                        end
                    end else begin
                        deb_cnt <= '0;
                    end
                end
                default: begin
                    state   <= ST_SCAN;
                    deb_cnt <= '0;
                end
            endcase
        end
    end

    // strobe-control outputs toward the row driver
    always_comb begin
        scan_en = (state == ST_SCAN);
        adv     = ((state == ST_SCAN) && sample_tick && !hit) ||
                  ((state == ST_HELD) && !hit && (deb_cnt == DEB_LAST));
        restart = (state == ST_CONFIRM) && !same;
    end

    assign key_held = (state == ST_HELD);

    assert_cnt_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        deb_cnt < DW'(DEBOUNCE));

    assert_valid_single_R6: assert property (@(posedge clk) disable iff (!rst_n)
        key_valid |=> !key_valid);

    assert_valid_with_held_R6: assert property (@(posedge clk) disable iff (!rst_n)
        key_valid |-> key_held);

    initial begin
        assert (DEBOUNCE >= 2) else $error("DEBOUNCE must be at least 2");
    end
endmodule

// File: rtl/kpd_scanner.sv
// Top level of the matrix keypad scanner.
// It connects the synchronizer, the walking-zero row driver and the debounce FSM.
// Assumes: the column lines are pulled high externally and a closed switch links its row and column.
module kpd_scanner #(
    parameter int ROWS     = 4,
    parameter int COLS     = 4,
    parameter int SETTLE   = 4,
    parameter int DEBOUNCE = 4,
    localparam int RW      = (ROWS > 1) ? $clog2(ROWS) : 1,
    localparam int KW      = $clog2(ROWS * COLS)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [COLS-1:0] col_n,
    output logic [ROWS-1:0] row_n,
    output logic [KW-1:0]   key_code,
    output logic            key_valid,
    output logic            key_held
);
    logic [COLS-1:0] col_s;
    logic [RW-1:0]   row_idx;
    logic            sample_tick;
    logic            scan_en;
    logic            adv;
    logic            restart;

    kpd_sync #(.W(COLS)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (col_n),
        .dout  (col_s)
    );

    kpd_row_drv #(.ROWS(ROWS), .SETTLE(SETTLE)) u_rows (
        .clk         (clk),
        .rst_n       (rst_n),
        .scan_en     (scan_en),
        .adv         (adv),
        .restart     (restart),
        .row_idx     (row_idx),
        .row_n       (row_n),
        .sample_tick (sample_tick)
    );

    kpd_debounce #(.ROWS(ROWS), .COLS(COLS), .DEBOUNCE(DEBOUNCE)) u_deb (
        .clk         (clk),
        .rst_n       (rst_n),
        .col_s       (col_s),
        .row_idx     (row_idx),
        .sample_tick (sample_tick),
        .scan_en     (scan_en),
        .adv         (adv),
        .restart     (restart),
        .key_code    (key_code),
        .key_valid   (key_valid),
        .key_held    (key_held)
    );

    assert_row_frozen_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (key_held && $past(key_held)) |-> $stable(row_n));

    assert_release_advance_R8: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(key_held) |-> (row_n != $past(row_n)));
endmodule

// File: tb/tb_kpd_scanner.sv
module tb_kpd_scanner;
    localparam int CLK_PERIOD = 10;
    localparam int SET = 4;
    localparam int DEB = 5;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [3:0] col_n;
    logic [3:0] row_n;
    logic [3:0] key_code;
    logic       key_valid;
    logic       key_held;

    int checks = 0;
    int errors = 0;

    // keypad stimulus
    logic press = 1'b0;
    logic multi = 1'b0;
    int   krow = 0, kcol = 0, kcol2 = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    kpd_scanner #(.ROWS(4), .COLS(4), .SETTLE(SET), .DEBOUNCE(DEB)) dut (
        .clk(clk), .rst_n(rst_n), .col_n(col_n), .row_n(row_n),
        .key_code(key_code), .key_valid(key_valid), .key_held(key_held)
    );

    // switch matrix: a closed key pulls its column low while its row is strobed
    always_comb begin
        for (int c = 0; c < 4; c++)
            col_n[c] = !(press && !row_n[krow] && (c == kcol || (multi && c == kcol2)));
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    // behavioural reference model, stepped at negedge for the next rising edge
    int   m_state = 0, m_row = 0, m_scnt = 0, m_dc = 0, m_cand = 0, m_code = 0;
    bit   m_valid = 0;
    logic [3:0] m_s1 = 4'hF, m_s2 = 4'hF;
    bit   m_ready = 0;
    int   pulses = 0;
    int   last_code = -1;

    function automatic int lowest(input logic [3:0] p);
        for (int c = 0; c < 4; c++) if (p[c]) return c;
        return -1;
    endfunction

    always @(negedge clk) begin
        if (m_ready) begin
            check(row_n == ~(4'b1 << m_row), "R2 R3 row drive", row_n, ~(4'b1 << m_row) & 4'hF);
            check(key_valid == m_valid, "R5 key_valid", key_valid, m_valid);
            check(key_held == (m_state == 2), "R6 key_held", key_held, m_state == 2);
            check(key_code == m_code, "R4 key_code", key_code, m_code);
        end
        if (key_valid) begin
            pulses++;
            last_code = key_code;
        end
        if (!rst_n) begin
            m_state = 0; m_row = 0; m_scnt = 0; m_dc = 0; m_cand = 0; m_code = 0;
            m_valid = 0; m_s1 = 4'hF; m_s2 = 4'hF;
            m_ready = 1;
        end else begin
            logic [3:0] p;
            int lc;
            p = ~m_s2;
            lc = lowest(p);
            m_valid = 0;
            case (m_state)
                0: if (m_scnt == SET - 1) begin
                       if (lc >= 0) begin m_state = 1; m_cand = lc; m_dc = 1; end
                       else begin m_row = (m_row + 1) % 4; m_scnt = 0; end
                   end else m_scnt++;
                1: if (lc >= 0 && lc == m_cand) begin
                       if (m_dc == DEB - 1) begin
                           m_state = 2; m_valid = 1; m_code = m_row * 4 + m_cand; m_dc = 0;
                       end else m_dc++;
                   end else begin m_state = 0; m_dc = 0; m_scnt = 0; end
                default: if (lc < 0) begin
                       if (m_dc == DEB - 1) begin
                           m_state = 0; m_dc = 0; m_row = (m_row + 1) % 4; m_scnt = 0;
                       end else m_dc++;
                   end else m_dc = 0;
            endcase
            m_s2 = m_s1;
            m_s1 = col_n;
        end
    end

    task automatic tick(input int n);
        repeat (n) begin @(posedge clk); #1; end
    endtask

    task automatic press_key(input int r, input int c, input int exp_code, input string req);
        int waited = 0;
        pulses = 0;
        krow = r; kcol = c; press = 1'b1;
        while (!key_held && waited < 200) begin tick(1); waited++; end
        tick(30);
        check(key_held == 1'b1, "R6 held during press", key_held, 1);
        check(row_n == ~(4'b1 << r), "R7 row frozen on key", row_n, ~(4'b1 << r) & 4'hF);
        check(last_code == exp_code, req, last_code, exp_code);
        press = 1'b0;
        multi = 1'b0;
        tick(DEB + 4);
        check(key_held == 1'b0, "R8 released", key_held, 0);
        check(pulses == 1, "R6 one pulse per press", pulses, 1);
        tick(20);
    endtask

    initial begin
        tick(4);
        check(row_n == 4'b1110, "R1 reset row", row_n, 14);
        check(key_valid == 1'b0 && key_held == 1'b0, "R1 reset flags", {key_valid, key_held}, 0);
        check(key_code == 4'd0, "R1 reset code", key_code, 0);
        rst_n = 1'b1;
        tick(40);
        press_key(2, 1, 9, "R4 code row2 col1");
        press_key(0, 0, 0, "R4 code row0 col0");
        press_key(0, 1, 1, "R4 code row0 col1");
        press_key(3, 3, 15, "R4 code row3 col3");
        multi = 1'b1; kcol2 = 3;
        press_key(1, 2, 6, "R9 lowest column");
        // bouncing contact, never steady for DEB samples
        pulses = 0;
        krow = 1; kcol = 0;
        for (int i = 0; i < 40; i++) begin press = ~press; tick(2); end
        press = 1'b0;
        tick(DEB + 4);
        check(pulses == 0, "R5 bounce rejected", pulses, 0);
        check(key_held == 1'b0, "R5 no hold after bounce", key_held, 0);
        // release bounce while held: short gaps must not release
        pulses = 0;
        krow = 3; kcol = 2; press = 1'b1;
        tick(60);
        for (int i = 0; i < 5; i++) begin press = 1'b0; tick(2); press = 1'b1; tick(3); end
        check(key_held == 1'b1, "R8 short gaps keep hold", key_held, 1);
        press = 1'b0;
        tick(DEB + 4);
        check(pulses == 1, "R6 single pulse with release bounce", pulses, 1);
        check(last_code == 14, "R4 code row3 col2", last_code, 14);
        // reset mid-scan
        tick(7);
        rst_n = 1'b0;
        tick(2);
        check(row_n == 4'b1110, "R1 reset mid-scan", row_n, 14);
        rst_n = 1'b1;
        tick(20);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        errors++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule